// File: doc/BRIEF.md
# Countdown Interrupt Timer with Vector Entry

This block is a memory-mapped countdown timer that belongs to a per-core local interrupt controller. Software loads a start value, and the block counts it down at the input clock divided by a selectable ratio. When the count passes through zero, the block raises an interrupt request tagged with an 8-bit vector that software has programmed. The request stays up until software writes to an end-of-interrupt register. A vector entry register chooses the vector, a mask, and either one-shot or periodic operation. A global software-enable register gates every delivery.

Access is through a simple single-cycle 32-bit register port. A write is taken on the clock edge while `bus_wr` is high. A read is combinational from `bus_addr`. The divided tick comes from a free-running prescaler. The prescaler is never reset by register writes, so the first tick after a start can arrive anywhere inside one divide period.

Top module: `lit_timer`

## Requirements
- R1: After reset the vector entry reads 0x00010000 (masked, one-shot, vector 0). The start count, live count, divide register and enable register all read 0. `irq_req` is low and `irq_vec` is 0.
- R2: Only these bits store and read back; all other bits read 0:
  - enable register (0x0F0): bits 9:0;
  - vector entry (0x320): bits 17, 16 and 7:0;
  - divide register (0x3E0): bits 3, 1 and 0;
  - start count (0x380): all 32 bits.

  The live count (0x390) ignores writes. Every other offset, including 0x0B0, reads 0 and ignores writes.
- R3: The divide code formed from bits {3,1,0} of the divide register sets the ratio: 000→2, 001→4, 010→8, 011→16, 100→32, 101→64, 110→128, 111→1. Bit 2 is ignored. A new code takes effect at the next wrap of the free-running prescaler. The count steps down by one on each divided tick.
- R4: In one-shot mode (vector entry bit 17 = 0), a start value N gives exactly one request, on the Nth tick. The live count then stays at 0. At ratio 1, `irq_req` rises N clock edges after the edge that took the write.
- R5: In periodic mode (bit 17 = 1), the count reloads the start value on the tick that would take it from 1 to 0. Requests are then spaced exactly N × ratio clocks apart.
- R6: While the mask bit (vector entry bit 16) is 1, a zero crossing raises no request.
- R7: While enable register bit 8 is 0, a zero crossing raises no request.
- R8: Writing 0 to the start count stops the timer with the live count at 0, and no request follows.
- R9: `irq_req` stays high, with `irq_vec` holding the vector captured at the crossing, until any write to offset 0x0B0. That write clears it on the same edge. A crossing while a request is already pending is dropped, not queued. `irq_vec` reads 0 while no request is pending.
- R10: A write to the start count while the timer is running restarts the countdown from the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_req | output | 1 | Pending timer interrupt request |
| irq_vec | output | 8 | Vector of the pending request, 0 when none |

## Verification
The assertions assume the following about the inputs:
- writes arrive one per cycle;
- an end-of-interrupt write does not land on the same edge as a new zero crossing (when it does, the new request wins, and the hold property is written to tolerate that);
- reset is held for at least one edge.

The stimulus meets these conditions in three ways:
- It issues an end-of-interrupt write one cycle after each request is seen, and uses periods of at least four clocks, so the write cannot meet the next crossing.
- It stops the timer and clears any pending request before it changes the divide code.
- It waits longer than the slowest prescaler period before measuring, so that each randomly chosen code has taken effect.

// File: rtl/lit_pkg.sv
package lit_pkg;

  localparam int OFF_W = 12;

  localparam logic [OFF_W-1:0] OFF_EOI  = 12'h0B0;
  localparam logic [OFF_W-1:0] OFF_SWEN = 12'h0F0;
  localparam logic [OFF_W-1:0] OFF_VENT = 12'h320;
  localparam logic [OFF_W-1:0] OFF_INIT = 12'h380;
  localparam logic [OFF_W-1:0] OFF_CUR  = 12'h390;
  localparam logic [OFF_W-1:0] OFF_DIV  = 12'h3E0;

  typedef struct packed {
    logic       periodic;
    logic       mask;
    logic [7:0] vec;
  } vent_t;

  localparam vent_t VENT_RST = '{periodic: 1'b0, mask: 1'b1, vec: 8'h00};

  // compact code {b3,b1,b0} -> log2 of the ratio; 111 wraps to 0 (ratio 1)
  function automatic logic [2:0] div_shift(input logic [2:0] idx);
    return idx + 3'd1;
  endfunction

  // terminal value of the prescaler for a given log2 ratio
  function automatic logic [6:0] pre_limit(input logic [2:0] shift);
    return 7'((8'd1 << shift) - 8'd1);
  endfunction

endpackage

// File: rtl/lit_prescaler.sv
module lit_prescaler
  import lit_pkg::*;
#(
  parameter int PRE_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] shift_req,
  output logic       tick
);

  logic [PRE_W-1:0] pcnt_q;
  logic [2:0]       shift_act_q;
  logic             wrap;

  assign wrap = (pcnt_q == PRE_W'(pre_limit(shift_act_q)));
  assign tick = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q      <= '0;
      shift_act_q <= div_shift(3'd0);
    end else if (wrap) begin
      pcnt_q      <= '0;
      shift_act_q <= shift_req;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lit_counter.sv
module lit_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur_cnt,
  output logic             zero_evt
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_one;

  assign at_one   = (cnt_q == CNT_W'(1));
  assign zero_evt = tick && at_one && !load;
  assign cur_cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && cnt_q != '0) begin
      if (at_one) cnt_q <= periodic ? reload_val : '0;
      else        cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/lit_regs.sv
module lit_regs
  import lit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [OFF_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cur_cnt,
  output logic [DATA_W-1:0] bus_rdata,
  output vent_t             vent,
  output logic [CNT_W-1:0]  init_cnt,
  output logic [2:0]        div_idx,
  output logic [9:0]        swen,
  output logic              init_wr,
  output logic              eoi_wr
);

  vent_t            vent_q;
  logic [CNT_W-1:0] init_q;
  logic [2:0]       div_q;
  logic [9:0]       swen_q;

  assign init_wr = bus_wr && (bus_addr == OFF_INIT);
  assign eoi_wr  = bus_wr && (bus_addr == OFF_EOI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vent_q <= VENT_RST;
      init_q <= '0;
      div_q  <= 3'b000;
      swen_q <= '0;
    end else if (bus_wr) begin
      unique case (bus_addr)
        OFF_VENT: vent_q <= '{periodic: bus_wdata[17], mask: bus_wdata[16],
                              vec: bus_wdata[7:0]};
        OFF_INIT: init_q <= bus_wdata[CNT_W-1:0];
        OFF_DIV:  div_q  <= {bus_wdata[3], bus_wdata[1], bus_wdata[0]};
        OFF_SWEN: swen_q <= bus_wdata[9:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_VENT: bus_rdata = DATA_W'({14'd0, vent_q.periodic, vent_q.mask, 8'd0, vent_q.vec});
      OFF_INIT: bus_rdata = DATA_W'(init_q);
      OFF_CUR:  bus_rdata = DATA_W'(cur_cnt);
      OFF_DIV:  bus_rdata = DATA_W'({div_q[2], 1'b0, div_q[1:0]});
      OFF_SWEN: bus_rdata = DATA_W'(swen_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign vent     = vent_q;
  assign init_cnt = init_q;
  assign div_idx  = div_q;
  assign swen     = swen_q;

endmodule

// File: rtl/lit_timer.sv
module lit_timer
  import lit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req,
  output logic [7:0]        irq_vec
);

  vent_t            vent_q;
  logic [CNT_W-1:0] init_cnt;
  logic [CNT_W-1:0] cur_cnt;
  logic [2:0]       div_idx;
  logic [9:0]       swen;
  logic             init_wr;
  logic             eoi_wr;
  logic             tick;
  logic             zero_evt;
  logic             sw_en;
  logic             deliver;
  logic             irq_q;
  logic [7:0]       vec_q;

  lit_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cur_cnt(cur_cnt), .bus_rdata(bus_rdata),
    .vent(vent_q), .init_cnt(init_cnt), .div_idx(div_idx), .swen(swen),
    .init_wr(init_wr), .eoi_wr(eoi_wr)
  );

  lit_prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .shift_req(div_shift(div_idx)), .tick(tick)
  );

  lit_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(init_wr),
    .load_val(bus_wdata[CNT_W-1:0]), .reload_val(init_cnt),
    .periodic(vent_q.periodic), .cur_cnt(cur_cnt), .zero_evt(zero_evt)
  );

  assign sw_en   = swen[8];
  assign deliver = zero_evt && !vent_q.mask && sw_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else if (deliver && (!irq_q || eoi_wr)) begin
      irq_q <= 1'b1;
      vec_q <= vent_q.vec;
    end else if (eoi_wr) begin
      irq_q <= 1'b0;
    end
  end

  assign irq_req = irq_q;
  assign irq_vec = irq_q ? vec_q : 8'h00;

endmodule

// File: rtl/lit_timer_chk.sv
module lit_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic [7:0]       irq_vec,
  input logic             eoi_wr,
  input logic             vec_mask,
  input logic             sw_en,
  input logic             zero_evt,
  input logic             tick,
  input logic             init_wr,
  input logic [CNT_W-1:0] cur_cnt
);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !eoi_wr |=> irq_req && $stable(irq_vec));

  p_eoi_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr && !zero_evt |=> !irq_req);

  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && vec_mask |=> !irq_req);

  p_swen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && !sw_en |=> !irq_req);

  p_stay_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_cnt == '0 && !init_wr |=> cur_cnt == '0);

  p_tick_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !init_wr |=> $stable(cur_cnt));

  p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(zero_evt));

endmodule

bind lit_timer lit_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
  .eoi_wr(eoi_wr), .vec_mask(vent_q.mask), .sw_en(sw_en),
  .zero_evt(zero_evt), .tick(tick), .init_wr(init_wr), .cur_cnt(cur_cnt)
);

// File: tb/lit_timer_tb_top.sv
module lit_timer_tb_top;

  localparam int CLK_P = 10;
  localparam int WDOG  = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lit_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic int ratio_of(input logic [3:0] code);
    case ({code[3], code[1:0]})
      3'b000: return 2;
      3'b001: return 4;
      3'b010: return 8;
      3'b011: return 16;
      3'b100: return 32;
      3'b101: return 64;
      3'b110: return 128;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic eoi();
    wr(12'h0B0, 32'hDEAD_BEEF);
  endtask

  task automatic wait_irq(output int n, output int t);
    n = 0;
    while (!irq_req && n < 4000) begin
      @(negedge clk);
      n++;
    end
    t = cyc;
  endtask

  task automatic quiet(input int cycles, input string tag);
    int hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq_req) hi++;
    end
    chk(hi == 0, tag, hi, 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=<%0d", WDOG, WDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, t1, t2;
    logic [31:0] v;
    process::self().srandom(32'd1234);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(irq_req == 1'b0, "R1 irq_req", irq_req, 0);
    chk(irq_vec == 8'h00, "R1 irq_vec", irq_vec, 0);
    rd_chk(12'h320, 32'h0001_0000, "R1 vector entry");
    rd_chk(12'h380, 32'h0, "R1 start count");
    rd_chk(12'h390, 32'h0, "R1 live count");
    rd_chk(12'h3E0, 32'h0, "R1 divide");
    rd_chk(12'h0F0, 32'h0, "R1 enable");

    // R2 implemented bits, read-only live count, holes
    wr(12'h320, 32'hFFFF_FFFF);
    rd_chk(12'h320, 32'h0003_00FF, "R2 vector bits");
    wr(12'h0F0, 32'hFFFF_FFFF);
    rd_chk(12'h0F0, 32'h0000_03FF, "R2 enable bits");
    wr(12'h3E0, 32'hFFFF_FFFF);
    rd_chk(12'h3E0, 32'h0000_000B, "R2 divide bits");
    wr(12'h380, 32'hFFFF_FFFF);
    rd_chk(12'h380, 32'hFFFF_FFFF, "R2 start bits");
    wr(12'h380, 32'h0);
    wr(12'h390, 32'h1234);
    rd_chk(12'h390, 32'h0, "R2 live count write ignored");
    wr(12'h004, 32'hFFFF_FFFF);
    rd_chk(12'h004, 32'h0, "R2 hole reads zero");
    rd_chk(12'h0B0, 32'h0, "R2 eoi reads zero");
    rd_chk(12'h324, 32'h0, "R2 near-offset reads zero");

    // enable, ratio 1, let the prescaler pick it up
    wr(12'h0F0, 32'h0000_01FF);
    wr(12'h3E0, 32'h0000_000B);
    repeat (140) @(negedge clk);

    // R4 one-shot
    wr(12'h320, 32'h0000_0042);
    wr(12'h380, 32'd5);
    wait_irq(n, t1);
    chk(n == 5, "R4 one-shot latency", n, 5);
    chk(irq_vec == 8'h42, "R9 vector carried", irq_vec, 8'h42);
    rd_chk(12'h390, 32'h0, "R4 live count at zero");
    repeat (20) @(negedge clk);
    chk(irq_req == 1'b1, "R9 request held", irq_req, 1);
    rd_chk(12'h390, 32'h0, "R4 live count stays zero");
    eoi();
    chk(irq_req == 1'b0, "R9 eoi clears", irq_req, 0);
    chk(irq_vec == 8'h00, "R9 vector zero when idle", irq_vec, 0);
    quiet(40, "R4 single request only");

    // R10 restart
    wr(12'h380, 32'd1000);
    repeat (10) @(negedge clk);
    wr(12'h380, 32'd50);
    wait_irq(n, t1);
    chk(n == 50, "R10 restart latency", n, 50);
    eoi();

    // R8 stop by zero
    wr(12'h380, 32'd300);
    repeat (5) @(negedge clk);
    wr(12'h380, 32'd0);
    rd_chk(12'h390, 32'h0, "R8 stopped count");
    quiet(400, "R8 no request after stop");

    // R5 periodic
    wr(12'h320, 32'h0002_0055);
    wr(12'h380, 32'd6);
    wait_irq(n, t1);
    eoi();
    wait_irq(n, t2);
    chk(t2 - t1 == 6, "R5 periodic spacing", t2 - t1, 6);
    chk(irq_vec == 8'h55, "R5 vector", irq_vec, 8'h55);

    // R9 not queued
    repeat (20) @(negedge clk);
    chk(irq_req == 1'b1 && irq_vec == 8'h55, "R9 pending kept", irq_vec, 8'h55);
    wr(12'h320, 32'h0003_0055);
    eoi();
    chk(irq_req == 1'b0, "R9 eoi clears pending", irq_req, 0);
    quiet(40, "R9 no queued request; R6 mask holds off");

    // R6 unmask lets requests through
    wr(12'h320, 32'h0002_0055);
    wait_irq(n, t1);
    chk(n >= 1 && n <= 7, "R6 unmasked delivery", n, 6);
    eoi();

    // R7 software enable
    wr(12'h0F0, 32'h0000_00FF);
    eoi();
    chk(irq_req == 1'b0, "R7 cleared", irq_req, 0);
    quiet(40, "R7 disabled no request");
    wr(12'h0F0, 32'h0000_01FF);
    wait_irq(n, t1);
    chk(n >= 1 && n <= 7, "R7 re-enabled delivery", n, 6);
    eoi();

    // R3 ratios: directed ends then random codes
    for (int it = 0; it < 10; it++) begin
      logic [3:0] code;
      int cnt, r;
      if (it == 0)      code = 4'hB;
      else if (it == 1) code = 4'hA;
      else              code = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                                2'($urandom_range(0, 3))};
      cnt = int'($urandom_range(4, 12));
      r   = ratio_of(code);
      wr(12'h380, 32'd0);
      eoi();
      wr(12'h3E0, {28'd0, code});
      repeat (140) @(negedge clk);
      wr(12'h380, cnt);
      wait_irq(n, t1);
      eoi();
      wait_irq(n, t2);
      chk(t2 - t1 == cnt * r, $sformatf("R3 ratio code 0x%0h count %0d", code, cnt),
          t2 - t1, cnt * r);
    end
    wr(12'h380, 32'd0);
    eoi();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule